// File: doc/BRIEF.md
# Lockable Trace Buffer Read Window

This block holds a debug trace memory of 64-bit lines and presents it to software through a 16-bit data window on a simple register bus. While the debugger is armed, a capture port writes one line per strobe into a circular store. Once the debugger is disarmed, software unlocks the window and reads the store back one half-word at a time. An internal read pointer moves forward by one half-word on every accepted read.

Reads are accepted only when four conditions all hold: the window is unlocked, the debugger is disarmed, the device is not secured, and trace-source select is set. Any other read returns zero and leaves the pointer where it was. Arming the debugger locks the window. Only an aligned word write to the window while disarmed unlocks it. That write moves the pointer to the first half-word of the oldest captured line and stores nothing.

A control state machine has three states. HELD means disarmed and locked, and it is the state after reset. OPEN means disarmed and unlocked. ARMED means capturing and locked. The transitions are ARM_SET (HELD or OPEN to ARMED, on an arm write of 1), DISARM (ARMED to HELD, on an arm write of 0), UNLOCK (HELD to OPEN, on an aligned word write to the window) and RELOAD (OPEN to OPEN, on the same write, which restarts the pointer). When ARM_SET and UNLOCK or RELOAD are requested in the same cycle, ARM_SET wins. Reset returns the state machine and all pointers to their initial values and leaves the stored lines as they were.

Top module: `tbw_window`

## Requirements
- R1: After reset the state is HELD, `bus_rdata` is 0, and every read returns 0 until an unlock.
- R2: An aligned word write (`bus_word`=1, `bus_a0`=0) to the window while disarmed unlocks it. The pointer moves to half-word 0 of the oldest line, which is line 0 unless capture has wrapped. Stored lines are not altered.
- R3: An accepted read loads `bus_rdata` at the clock edge of the request. The four reads of a line return bits [63:48], [47:32], [31:16] and [15:0], in that order, and each accepted read advances the pointer by one half-word.
- R4: After half-word 3 of line DEPTH-1, the pointer wraps to half-word 0 of line 0.
- R5: An arm write of 1 enters ARMED. After a later arm write of 0, reads return 0 until a new unlock.
- R6: A byte read (`bus_word`=0) or a misaligned read (`bus_a0`=1) returns 0 and does not advance the pointer.
- R7: A read while armed returns 0 and does not advance the pointer.
- R8: A read while `secure`=1 or `src_trace`=0 returns 0 and does not advance the pointer.
- R9: While armed, each `cap_valid` strobe stores `cap_data` into the next line in circular order. While disarmed, `cap_valid` has no effect.
- R10: Once capture has wrapped, the oldest line is the next line to be written, and an unlock starts reading there.
- R11: While armed, and while disarmed if the write is a byte or misaligned write, a write to the window does not unlock it.
- R12: Reset clears the state machine and the pointers but keeps the stored lines.
- R13: A read in the same cycle as an arm write of 1 is judged on the state before that edge. An unlock write in the same cycle as an arm write of 1 is discarded, and the block enters ARMED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; stored lines are kept |
| bus_req | input | 1 | Window access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_a0 | input | 1 | Address bit 0; 1 = misaligned |
| arm_wr | input | 1 | Write strobe for the arm control bit |
| arm_val | input | 1 | Value written to the arm control bit |
| secure | input | 1 | Device secured; blocks reads |
| src_trace | input | 1 | Trace-source select; reads need it set |
| cap_valid | input | 1 | Capture strobe |
| cap_data | input | 64 | Line to capture |
| bus_rdata | output | 16 | Read data, registered on each read request |

## Verification
The arm control write can coincide with a window access in the same cycle. The bench provokes this in two ways. First, it issues an aligned read in OPEN in the same cycle as an arm write of 1, and expects valid data with the pointer advanced. Second, it issues an unlock write in HELD in the same cycle as an arm write of 1. After a disarm, it expects reads to stay at zero, because the discarded unlock must not have opened the window. A behavioural model in the bench follows every clock, and `bus_rdata` is compared with the model each cycle.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

    localparam int SLICE_W = 16;
    localparam int LINE_W  = 64;
    localparam int SLICES  = LINE_W / SLICE_W;
    localparam int SLICE_AW = $clog2(SLICES);

    typedef enum logic [1:0] {
        ST_HELD  = 2'd0,
        ST_OPEN  = 2'd1,
        ST_ARMED = 2'd2
    } tbw_state_e;

endpackage

// File: rtl/tbw_ctrl.sv
module tbw_ctrl
    import tbw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_wr,
    input  logic       arm_val,
    input  logic       unlock_req,
    output tbw_state_e st_q,
    output logic       armed,
    output logic       rd_open,
    output logic       reload
);

    tbw_state_e st_d;
    logic       arm_set;
    logic       arm_clr;

    assign arm_set = arm_wr && arm_val;
    assign arm_clr = arm_wr && !arm_val;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_HELD;
        end else begin
            st_q <= st_d;
        end
    end

    // next state: ARM_SET has priority over UNLOCK / RELOAD
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HELD: begin
                if (arm_set)         st_d = ST_ARMED;   // ARM_SET
                else if (unlock_req) st_d = ST_OPEN;    // UNLOCK
            end
            ST_OPEN: begin
                if (arm_set)         st_d = ST_ARMED;   // ARM_SET
                else                 st_d = ST_OPEN;    // RELOAD or stay
            end
            ST_ARMED: begin
                if (arm_clr)         st_d = ST_HELD;    // DISARM
            end
            default:                 st_d = ST_HELD;
        endcase
    end

    // outputs
    always_comb begin
        armed   = 1'b0;
        rd_open = 1'b0;
        reload  = 1'b0;
        unique case (st_q)
            ST_HELD:  reload  = unlock_req && !arm_set;
            ST_OPEN: begin
                rd_open = 1'b1;
                reload  = unlock_req && !arm_set;
            end
            ST_ARMED: armed   = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/tbw_store.sv
module tbw_store
    import tbw_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int LAW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_we,
    input  logic [LINE_W-1:0] cap_data,
    input  logic [LAW-1:0]    rd_line,
    output logic [LINE_W-1:0] rd_word,
    output logic [LAW-1:0]    wr_line,
    output logic [LAW-1:0]    oldest
);

    logic [LINE_W-1:0] mem [DEPTH];
    logic              wrapped;
    logic              at_end;

    assign at_end = (wr_line == LAW'(DEPTH - 1));

    // line storage: no reset, contents survive every reset
    always_ff @(posedge clk) begin
        if (cap_we) begin
            mem[wr_line] <= cap_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_line <= '0;
            wrapped <= 1'b0;
        end else if (cap_we) begin
            if (at_end) begin
                wr_line <= '0;
                wrapped <= 1'b1;
            end else begin
                wr_line <= wr_line + LAW'(1);
            end
        end
    end

    assign oldest  = wrapped ? wr_line : '0;
    assign rd_word = mem[rd_line];

endmodule

// File: rtl/tbw_rdptr.sv
module tbw_rdptr
    import tbw_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int LAW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reload,
    input  logic [LAW-1:0]      reload_line,
    input  logic                step,
    output logic [LAW-1:0]      rd_line,
    output logic [SLICE_AW-1:0] rd_slice
);

    logic last_slice;
    logic last_line;

    assign last_slice = (rd_slice == SLICE_AW'(SLICES - 1));
    assign last_line  = (rd_line == LAW'(DEPTH - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_line  <= '0;
            rd_slice <= '0;
        end else if (reload) begin
            rd_line  <= reload_line;
            rd_slice <= '0;
        end else if (step) begin
            if (last_slice) begin
                rd_slice <= '0;
                rd_line  <= last_line ? '0 : rd_line + LAW'(1);
            end else begin
                rd_slice <= rd_slice + SLICE_AW'(1);
            end
        end
    end

endmodule

// File: rtl/tbw_window.sv
module tbw_window
    import tbw_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int LAW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic        bus_word,
    input  logic        bus_a0,
    input  logic        arm_wr,
    input  logic        arm_val,
    input  logic        secure,
    input  logic        src_trace,
    input  logic        cap_valid,
    input  logic [63:0] cap_data,
    output logic [15:0] bus_rdata
);

    tbw_state_e          st_q;
    logic                armed;
    logic                rd_open;
    logic                reload;
    logic                aligned;
    logic                unlock_req;
    logic                rd_access;
    logic                rd_ok;
    logic [LAW-1:0]      rd_line;
    logic [SLICE_AW-1:0] rd_slice;
    logic [LAW-1:0]      wr_line;
    logic [LAW-1:0]      oldest;
    logic [LINE_W-1:0]   rd_word;
    logic [SLICE_W-1:0]  slice_arr [SLICES];
    logic [SLICE_W-1:0]  rdata_q;

    assign aligned    = bus_word && !bus_a0;
    assign unlock_req = bus_req && bus_we && aligned;
    assign rd_access  = bus_req && !bus_we;
    assign rd_ok      = rd_access && aligned && rd_open && !secure && src_trace;

    tbw_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_wr     (arm_wr),
        .arm_val    (arm_val),
        .unlock_req (unlock_req),
        .st_q       (st_q),
        .armed      (armed),
        .rd_open    (rd_open),
        .reload     (reload)
    );

    tbw_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_we   (cap_valid && armed),
        .cap_data (cap_data),
        .rd_line  (rd_line),
        .rd_word  (rd_word),
        .wr_line  (wr_line),
        .oldest   (oldest)
    );

    tbw_rdptr #(.DEPTH(DEPTH)) u_rdptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .reload      (reload),
        .reload_line (oldest),
        .step        (rd_ok),
        .rd_line     (rd_line),
        .rd_slice    (rd_slice)
    );

    // slice 0 is the most significant half-word
    for (genvar g = 0; g < SLICES; g++) begin : g_slice
        assign slice_arr[g] = rd_word[LINE_W-1-g*SLICE_W -: SLICE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_access) begin
            rdata_q <= rd_ok ? slice_arr[rd_slice] : '0;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/tbw_window_chk.sv
module tbw_window_chk
    import tbw_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int LAW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_req,
    input logic                bus_we,
    input logic                bus_word,
    input logic                bus_a0,
    input logic                arm_wr,
    input logic                arm_val,
    input logic                secure,
    input logic                src_trace,
    input logic                cap_valid,
    input logic [15:0]         bus_rdata,
    input tbw_state_e          st,
    input logic [LAW-1:0]      rd_line,
    input logic [SLICE_AW-1:0] rd_slice,
    input logic [LAW-1:0]      wr_line
);

    logic rd;
    assign rd = bus_req && !bus_we;

    assert_bad_size_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd && (!bus_word || bus_a0) |=> bus_rdata == 16'h0);

    assert_bad_size_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd && (!bus_word || bus_a0) |=> $stable(rd_line) && $stable(rd_slice));

    assert_armed_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd && st == ST_ARMED |=> bus_rdata == 16'h0 && $stable(rd_slice));

    assert_gated_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd && (secure || !src_trace) |=> bus_rdata == 16'h0 && $stable(rd_slice));

    assert_arm_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr && arm_val |=> st == ST_ARMED);

    assert_armed_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && st == ST_ARMED && !(arm_wr && !arm_val) |=> st == ST_ARMED);

    assert_cap_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid && st == ST_ARMED |=>
            wr_line == (($past(wr_line) == LAW'(DEPTH - 1)) ? '0 : $past(wr_line) + LAW'(1)));

    assert_cap_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid && st != ST_ARMED |=> $stable(wr_line));

endmodule

bind tbw_window tbw_window_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_word  (bus_word),
    .bus_a0    (bus_a0),
    .arm_wr    (arm_wr),
    .arm_val   (arm_val),
    .secure    (secure),
    .src_trace (src_trace),
    .cap_valid (cap_valid),
    .bus_rdata (bus_rdata),
    .st        (st_q),
    .rd_line   (rd_line),
    .rd_slice  (rd_slice),
    .wr_line   (wr_line)
);

// File: tb/sim_tbw_window.sv
module sim_tbw_window;

    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 0, bus_we = 0, bus_word = 0, bus_a0 = 0;
    logic        arm_wr = 0, arm_val = 0, secure = 0, src_trace = 1;
    logic        cap_valid = 0;
    logic [63:0] cap_data = '0;
    logic [15:0] bus_rdata;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    done = 0;

    always #2.5 clk = ~clk;

    tbw_window #(.DEPTH(D)) u0 (.*);

    // behavioural model
    logic [63:0] mm [D];
    int          m_state;   // 0 held, 1 open, 2 armed
    int          m_wr, m_wrapped, m_line, m_slice;
    logic [15:0] m_rdata;

    always @(posedge clk) begin
        bit ok, rd, unl, aset;
        if (!rst_n) begin
            m_state = 0; m_wr = 0; m_wrapped = 0;
            m_line = 0; m_slice = 0; m_rdata = 0;
        end else begin
            rd   = bus_req && !bus_we;
            unl  = bus_req && bus_we && bus_word && !bus_a0;
            aset = arm_wr && arm_val;
            ok   = rd && bus_word && !bus_a0 && m_state == 1 && !secure && src_trace;
            if (rd) m_rdata = ok ? 16'((mm[m_line] >> (16 * (3 - m_slice)))) : 16'h0;
            if (m_state == 2 && cap_valid) begin
                mm[m_wr] = cap_data;
                if (m_wr == D - 1) begin m_wr = 0; m_wrapped = 1; end
                else m_wr++;
            end
            if (ok) begin
                if (m_slice == 3) begin
                    m_slice = 0;
                    m_line = (m_line == D - 1) ? 0 : m_line + 1;
                end else m_slice++;
            end
            if (m_state == 2) begin
                if (arm_wr && !arm_val) m_state = 0;
            end else if (aset) begin
                m_state = 2;
            end else if (unl) begin
                m_state = 1;
                m_line  = m_wrapped ? m_wr : 0;
                m_slice = 0;
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (bus_rdata !== m_rdata) begin
                errors++;
                $display("FAIL %s: bus_rdata actual %h expected %h", tag, bus_rdata, m_rdata);
            end
        end
    end

    task automatic idle();
        bus_req = 0; bus_we = 0; bus_word = 0; bus_a0 = 0;
        arm_wr = 0; arm_val = 0; cap_valid = 0;
    endtask

    task automatic step(); @(negedge clk); idle(); endtask

    task automatic acc(input bit we, input bit word, input bit a0);
        bus_req = 1; bus_we = we; bus_word = word; bus_a0 = a0;
        step();
    endtask

    task automatic arm(input bit v);
        arm_wr = 1; arm_val = v;
        step();
    endtask

    task automatic cap(input int i);
        cap_valid = 1;
        cap_data = {16'hA000 + 16'(i), 16'hB000 + 16'(i), 16'hC000 + 16'(i), 16'hD000 + 16'(i)};
        step();
    endtask

    task automatic expect16(input string r, input logic [15:0] exp);
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s: bus_rdata actual %h expected %h", r, bus_rdata, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual hang expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        tag = "R1"; expect16("R1", 16'h0);
        acc(0, 1, 0); expect16("R1", 16'h0);

        tag = "R9"; arm(1);
        for (int i = 0; i < D; i++) cap(i);
        tag = "R11"; acc(1, 1, 0);
        tag = "R7"; acc(0, 1, 0); expect16("R7", 16'h0);
        tag = "R5"; arm(0);
        acc(0, 1, 0); expect16("R5", 16'h0);
        tag = "R11"; acc(1, 0, 0); acc(1, 1, 1);
        acc(0, 1, 0); expect16("R11", 16'h0);

        tag = "R2"; acc(1, 1, 0);
        tag = "R3"; acc(0, 1, 0); expect16("R3", 16'hA000);
        tag = "R6"; acc(0, 0, 0); expect16("R6", 16'h0);
        acc(0, 1, 1); expect16("R6", 16'h0);
        tag = "R3"; acc(0, 1, 0); expect16("R3", 16'hB000);
        tag = "R8"; secure = 1; acc(0, 1, 0); expect16("R8", 16'h0);
        secure = 0; src_trace = 0; acc(0, 1, 0); expect16("R8", 16'h0);
        src_trace = 1;
        tag = "R3"; acc(0, 1, 0); expect16("R3", 16'hC000);
        acc(0, 1, 0); expect16("R3", 16'hD000);
        tag = "R9"; cap(40);
        tag = "R4";
        for (int i = 0; i < 4 * (D - 1); i++) acc(0, 1, 0);
        expect16("R4", 16'hD000 + 16'(D - 1));
        acc(0, 1, 0); expect16("R4", 16'hA000);

        tag = "R10"; arm(1);
        for (int i = 0; i < 3; i++) cap(16 + i);
        arm(0); acc(1, 1, 0);
        acc(0, 1, 0); expect16("R10", 16'hA003);

        tag = "R13"; arm_wr = 1; arm_val = 1; acc(0, 1, 0);
        expect16("R13", 16'hB003);
        arm(0);
        arm_wr = 1; arm_val = 1; acc(1, 1, 0);
        arm(0);
        acc(0, 1, 0); expect16("R13", 16'h0);

        tag = "R12"; rst_n = 0; step(); step(); rst_n = 1;
        acc(1, 1, 0);
        acc(0, 1, 0); expect16("R12", 16'hA010);
        step();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule